// File: doc/BRIEF.md
# Configuration Space Register File

This block holds the 256-byte configuration image of a single bus function. A requester reads and writes it by byte offset with accesses of one, two or four bytes, packed little-endian on a 32-bit data bus. Each written byte passes through a protection filter. The filter keeps identification, class and header bytes fixed. The rest of the read-only set depends on the layout named by the header-type byte at offset 0x0E.

Full-word writes into a base-address slot take a separate path. The stored word has its size bits cleared and its type bits put back, so software can size a region by writing all ones and reading the result. The expansion-ROM slot keeps its enable bit instead of taking type bits. A slot whose region size is zero is written like any other byte range.

Wide reads near the top of the space are narrowed so that they never wrap. When a write could change address decoding, the block raises a one-cycle request to an external decoder. Initial contents come from a parameter image at reset. Writes take effect at the clock edge, and read data appears one cycle after the request.

Top module: `cfg_space_regfile`

## Requirements
- R1: While `rst` is high, every byte is loaded from `INIT_IMAGE` (byte n at bits 8n+7:8n), and `rd_data` and `map_upd` are held at 0.
- R2: Length code 0 selects 1 byte, code 1 selects 2 bytes, and codes 2 and 3 select 4 bytes. A read packs the byte at the lowest offset into bits 7:0, zero-fills any unused upper bytes, appears on `rd_data` one cycle after `rd_en`, and holds while `rd_en` is low.
- R3: A 4-byte read is served in full only at offsets up to 0xFC; above that it becomes a 2-byte read. A 2-byte read is served only at offsets up to 0xFE; at 0xFF it becomes a 1-byte read.
- R4: An ordinary write stores data bits 8i+7:8i at offset+i for each selected byte. Bytes that would fall beyond offset 0xFF are dropped, with no wrap to offset 0x00.
- R5: When the header byte is 0x00 or 0x80, ordinary writes leave these offsets unchanged: 0x00-0x03, 0x08-0x0B, 0x0E, 0x10-0x27, 0x30-0x33 and 0x3D.
- R6: For any other header value, ordinary writes leave these offsets unchanged: 0x00-0x03, 0x08-0x0B, 0x0E, 0x38-0x3B and 0x3D. Offsets 0x10-0x27 and 0x30-0x33 are then writable.
- R7: A 4-byte write at an offset in 0x10-0x27 uses slot (offset-0x10)/4. If that slot's size is nonzero, the block stores (data AND NOT(size-1)) OR type at offset..offset+3, whatever the protection map says.
- R8: A 4-byte write at an offset in 0x30-0x33 uses slot 6, the ROM slot. If that size is nonzero, the block stores data AND (NOT(size-1) OR 1), which keeps bit 0.
- R9: A 4-byte write into a slot window whose size is zero is handled as an ordinary write under R4-R6.
- R10: `map_upd` pulses high for exactly one cycle, on the cycle after a write that took the R7/R8 masked path or whose bytes overlap offsets 0x04-0x05. In every other cycle it is low.
- R11: When a read and a write fall in the same cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_len | input | 2 | Write length code |
| wr_data | input | DATA_W | Write data, little-endian |
| rd_en | input | 1 | Read request for this cycle |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_len | input | 2 | Read length code |
| rd_data | output | DATA_W | Registered read data |
| map_upd | output | 1 | Decode-update request, one-cycle pulse |

## Verification
A read and a write can land in the same cycle, even on overlapping offsets, including a masked base-address write whose slot is being read. The bench provokes this with directed cases and with many random cycles where both requests are active and the offsets are biased toward the slot windows, the command bytes and the top of the space. It judges the outcome against a model that computes the expected read before it applies the write. Two instances, one per header layout, take the same stimulus so that both protection maps are exercised together.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam int unsigned NUM_SLOTS = 7;
  localparam int unsigned ROM_SLOT  = 6;
  localparam int unsigned OFS_CMD   = 4;
  localparam int unsigned OFS_HDR   = 14;
  localparam int unsigned BAR_FIRST = 16;
  localparam int unsigned BAR_END   = 40;
  localparam int unsigned ROM_FIRST = 48;
  localparam int unsigned ROM_END   = 52;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_HALF  = 2'd1,
    ACC_WORD  = 2'd2,
    ACC_WORDX = 2'd3
  } acc_len_e;

  // Byte count selected by a length code.
  function automatic logic [2:0] acc_bytes(logic [1:0] code);
    case (code)
      ACC_BYTE: acc_bytes = 3'd1;
      ACC_HALF: acc_bytes = 3'd2;
      default:  acc_bytes = 3'd4;
    endcase
  endfunction

  // Header values that select the plain-endpoint protection map.
  function automatic logic plain_header(logic [7:0] hdr);
    plain_header = (hdr == 8'h00) || (hdr == 8'h80);
  endfunction

endpackage

// File: rtl/cfg_ro_map.sv
module cfg_ro_map #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              plain_hdr,
  output logic              read_only
);

  logic fixed_ro;
  logic plain_ro;
  logic other_ro;

  always_comb begin
    fixed_ro = (byte_addr <= ADDR_W'(3))
            || ((byte_addr >= ADDR_W'(8)) && (byte_addr <= ADDR_W'(11)))
            || (byte_addr == ADDR_W'(14))
            || (byte_addr == ADDR_W'(61));
    plain_ro = ((byte_addr >= ADDR_W'(16)) && (byte_addr <= ADDR_W'(39)))
            || ((byte_addr >= ADDR_W'(48)) && (byte_addr <= ADDR_W'(51)));
    other_ro = (byte_addr >= ADDR_W'(56)) && (byte_addr <= ADDR_W'(59));
    read_only = fixed_ro || (plain_hdr ? plain_ro : other_ro);
  end

endmodule

// File: rtl/cfg_wr_ctrl.sv
module cfg_wr_ctrl
  import cfg_space_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = DATA_W / 8,
  parameter logic [NUM_SLOTS*DATA_W-1:0] SLOT_SIZE = '0,
  parameter logic [NUM_SLOTS*DATA_W-1:0] SLOT_TYPE = '0
) (
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [1:0]                  wr_len,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        plain_hdr,
  output logic [LANES-1:0]            lane_we,
  output logic [LANES-1:0][ADDR_W-1:0] lane_addr,
  output logic [LANES-1:0][7:0]       lane_byte,
  output logic                        upd_req
);

  logic [2:0]        nbytes;
  logic              bar_win;
  logic              rom_win;
  logic [2:0]        slot;
  logic [DATA_W-1:0] slot_size;
  logic [DATA_W-1:0] slot_type;
  logic              masked;
  logic [DATA_W-1:0] masked_word;
  logic [ADDR_W:0]   end_addr;
  logic              cmd_hit;

  always_comb begin
    nbytes  = acc_bytes(wr_len);
    bar_win = (wr_addr >= ADDR_W'(BAR_FIRST)) && (wr_addr < ADDR_W'(BAR_END));
    rom_win = (wr_addr >= ADDR_W'(ROM_FIRST)) && (wr_addr < ADDR_W'(ROM_END));
    slot    = rom_win ? 3'(ROM_SLOT) : 3'((wr_addr - ADDR_W'(BAR_FIRST)) >> 2);
    slot_size = '0;
    slot_type = '0;
    for (int s = 0; s < int'(NUM_SLOTS); s++) begin
      if (slot == 3'(s)) begin
        slot_size = SLOT_SIZE[s*DATA_W +: DATA_W];
        slot_type = SLOT_TYPE[s*DATA_W +: DATA_W];
      end
    end
    masked = wr_en && (nbytes == 3'd4) && (bar_win || rom_win) && (slot_size != '0);
    if (rom_win)
      masked_word = wr_data & (~(slot_size - DATA_W'(1)) | DATA_W'(1));
    else
      masked_word = (wr_data & ~(slot_size - DATA_W'(1))) | slot_type;
    end_addr = {1'b0, wr_addr} + (ADDR_W+1)'(nbytes);
    cmd_hit  = (wr_addr < ADDR_W'(OFS_CMD + 2)) && (end_addr > (ADDR_W+1)'(OFS_CMD));
    upd_req  = wr_en && (masked || cmd_hit);
  end

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    logic [ADDR_W:0] sum;
    logic            in_rng;
    logic            ro;

    assign sum    = {1'b0, wr_addr} + (ADDR_W+1)'(g);
    assign in_rng = (nbytes > 3'(g)) && !sum[ADDR_W];

    cfg_ro_map #(.ADDR_W(ADDR_W)) u_ro (
      .byte_addr (sum[ADDR_W-1:0]),
      .plain_hdr (plain_hdr),
      .read_only (ro)
    );

    assign lane_we[g]   = wr_en && in_rng && (masked || !ro);
    assign lane_addr[g] = sum[ADDR_W-1:0];
    assign lane_byte[g] = masked ? masked_word[8*g +: 8] : wr_data[8*g +: 8];
  end

endmodule

// File: rtl/cfg_rd_port.sv
module cfg_rd_port
  import cfg_space_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = DATA_W / 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [1:0]                   rd_len,
  output logic [LANES-1:0][ADDR_W-1:0] lane_raddr,
  input  logic [LANES-1:0][7:0]        lane_rbyte,
  output logic [DATA_W-1:0]            rd_data
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [2:0]        req_bytes;
  logic [2:0]        nb;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    req_bytes = acc_bytes(rd_len);
    if ((req_bytes == 3'd4) && (rd_addr <= ADDR_W'(DEPTH - 4)))
      nb = 3'd4;
    else if ((req_bytes >= 3'd2) && (rd_addr <= ADDR_W'(DEPTH - 2)))
      nb = 3'd2;
    else
      nb = 3'd1;
  end

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    assign lane_raddr[g]  = rd_addr + ADDR_W'(g);
    assign nxt[8*g +: 8] = (nb > 3'(g)) ? lane_rbyte[g] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= nxt;
  end

endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
  import cfg_space_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [(1<<ADDR_W)*8-1:0]    INIT_IMAGE = '0,
  parameter logic [NUM_SLOTS*DATA_W-1:0] SLOT_SIZE  = (NUM_SLOTS*DATA_W)'(64),
  parameter logic [NUM_SLOTS*DATA_W-1:0] SLOT_TYPE  = (NUM_SLOTS*DATA_W)'(1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_len,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_len,
  output logic [DATA_W-1:0] rd_data,
  output logic              map_upd
);

  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned LANES = DATA_W / 8;

  logic [7:0] cfg_mem [DEPTH];

  logic                         plain_hdr;
  logic [LANES-1:0]             lane_we;
  logic [LANES-1:0][ADDR_W-1:0] lane_addr;
  logic [LANES-1:0][7:0]        lane_byte;
  logic                         upd_req;
  logic [LANES-1:0][ADDR_W-1:0] lane_raddr;
  logic [LANES-1:0][7:0]        lane_rbyte;

  assign plain_hdr = plain_header(cfg_mem[ADDR_W'(OFS_HDR)]);

  cfg_wr_ctrl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LANES     (LANES),
    .SLOT_SIZE (SLOT_SIZE),
    .SLOT_TYPE (SLOT_TYPE)
  ) u_wr (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_len    (wr_len),
    .wr_data   (wr_data),
    .plain_hdr (plain_hdr),
    .lane_we   (lane_we),
    .lane_addr (lane_addr),
    .lane_byte (lane_byte),
    .upd_req   (upd_req)
  );

  cfg_rd_port #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_rd (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_len     (rd_len),
    .lane_raddr (lane_raddr),
    .lane_rbyte (lane_rbyte),
    .rd_data    (rd_data)
  );

  for (genvar g = 0; g < int'(LANES); g++) begin : g_rmux
    assign lane_rbyte[g] = cfg_mem[lane_raddr[g]];
  end

  // Byte storage: reset image load, then up to LANES byte writes per cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(DEPTH); i++)
        cfg_mem[i] <= INIT_IMAGE[i*8 +: 8];
    end else begin
      for (int g = 0; g < int'(LANES); g++)
        if (lane_we[g]) cfg_mem[lane_addr[g]] <= lane_byte[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) map_upd <= 1'b0;
    else     map_upd <= upd_req;
  end

endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              map_upd,
  input logic [7:0]        id_byte,
  input logic [7:0]        hdr_byte
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  // R10
  upd_src_chk: assert property (@(posedge clk) disable iff (rst)
    map_upd |-> $past(wr_en));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R3
  rd_top_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rd_addr == ADDR_W'(DEPTH - 1))) |=> (rd_data[DATA_W-1:8] == '0));

  // R3
  rd_top_half_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rd_addr >= ADDR_W'(DEPTH - 3))) |=> (rd_data[DATA_W-1:16] == '0));

  // R5
  ro_id_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(id_byte));

  // R6
  ro_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(hdr_byte));

endmodule

bind cfg_space_regfile cfg_space_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .map_upd  (map_upd),
  .id_byte  (cfg_mem[0]),
  .hdr_byte (cfg_mem[14])
);

// File: tb/tb_cfg_space_regfile.sv
`timescale 1ns/1ps
module tb_cfg_space_regfile;

  function automatic logic [2047:0] mk_img(int k, logic [7:0] hdr);
    logic [2047:0] v;
    for (int a = 0; a < 256; a++)
      v[a*8 +: 8] = (a == 14) ? hdr : 8'(a*7 + 3 + k*64);
    return v;
  endfunction

  localparam logic [2047:0] IMG0 = mk_img(0, 8'h00);
  localparam logic [2047:0] IMG1 = mk_img(1, 8'h01);
  localparam logic [223:0] SZ0 = {32'h800, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1000, 32'h20};
  localparam logic [223:0] TY0 = {32'h0,   32'h0, 32'h0, 32'h0, 32'h0, 32'h0,    32'h1};
  localparam logic [223:0] SZ1 = {32'h0,   32'h0, 32'h0, 32'h0, 32'h0, 32'h0,    32'h100};
  localparam logic [223:0] TY1 = {32'h0,   32'h0, 32'h0, 32'h0, 32'h0, 32'h0,    32'h8};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [1:0]  wr_len = '0, rd_len = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd0, rd1;
  logic        up0, up1;

  always #10 clk = ~clk;

  cfg_space_regfile #(.INIT_IMAGE(IMG0), .SLOT_SIZE(SZ0), .SLOT_TYPE(TY0)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_len(wr_len),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_len(rd_len),
    .rd_data(rd0), .map_upd(up0));

  cfg_space_regfile #(.INIT_IMAGE(IMG1), .SLOT_SIZE(SZ1), .SLOT_TYPE(TY1)) dut_b (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_len(wr_len),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_len(rd_len),
    .rd_data(rd1), .map_upd(up1));

  logic [7:0]  mdl [2][256];
  logic [31:0] last_rd [2];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [31:0] slot_val(int k, int s, bit want_type);
    logic [223:0] v;
    if (want_type) v = (k == 0) ? TY0 : TY1;
    else           v = (k == 0) ? SZ0 : SZ1;
    return v[s*32 +: 32];
  endfunction

  function automatic bit bro(logic [7:0] hdr, int a);
    bit common = (a <= 3) || (a >= 8 && a <= 11) || a == 14 || a == 61;
    if (hdr == 8'h00 || hdr == 8'h80)
      return common || (a >= 16 && a <= 39) || (a >= 48 && a <= 51);
    return common || (a >= 56 && a <= 59);
  endfunction

  function automatic int nbytes(logic [1:0] code);
    return (code == 2'd0) ? 1 : ((code == 2'd1) ? 2 : 4);
  endfunction

  function automatic logic [31:0] mread(int k, int a, logic [1:0] code);
    int n = nbytes(code);
    logic [31:0] v = '0;
    if (n == 4 && a > 252) n = 2;
    if (n == 2 && a > 254) n = 1;
    for (int i = 0; i < n; i++) v[8*i +: 8] = mdl[k][a+i];
    return v;
  endfunction

  task automatic mwrite(input int k, input int a, input logic [1:0] code,
                        input logic [31:0] d, output logic up);
    int n = nbytes(code);
    bit win = (n == 4) && ((a >= 16 && a < 40) || (a >= 48 && a < 52));
    int s = (a >= 48) ? 6 : (a - 16) / 4;
    logic [31:0] size = win ? slot_val(k, s, 0) : 32'h0;
    logic [31:0] v;
    if (size != 0) begin
      if (s == 6) v = d & (~(size - 1) | 32'h1);
      else        v = (d & ~(size - 1)) | slot_val(k, s, 1);
      for (int i = 0; i < 4; i++) mdl[k][a+i] = v[8*i +: 8];
      up = 1'b1;
    end else begin
      logic [7:0] hdr = mdl[k][14];
      for (int i = 0; i < n; i++)
        if (a + i <= 255 && !bro(hdr, a + i)) mdl[k][a+i] = d[8*i +: 8];
      up = (a < 6) && (a + n > 4);
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check registered outputs at the next negedge.
  task automatic step(input logic we, input logic [7:0] wa, input logic [1:0] wl,
                      input logic [31:0] wd, input logic re, input logic [7:0] ra,
                      input logic [1:0] rl, input string tag);
    logic [31:0] er [2];
    logic        eu [2];
    for (int k = 0; k < 2; k++) begin
      er[k] = re ? mread(k, ra, rl) : last_rd[k];
      eu[k] = 1'b0;
      if (we) mwrite(k, wa, wl, wd, eu[k]);
    end
    wr_en = we; wr_addr = wa; wr_len = wl; wr_data = wd;
    rd_en = re; rd_addr = ra; rd_len = rl;
    @(posedge clk);
    @(negedge clk);
    check({tag, " rd hdr0"}, rd0, er[0]);
    check({tag, " rd hdr1"}, rd1, er[1]);
    check({tag, " R10 upd hdr0"}, {31'b0, up0}, {31'b0, eu[0]});
    check({tag, " R10 upd hdr1"}, {31'b0, up1}, {31'b0, eu[1]});
    last_rd[0] = er[0];
    last_rd[1] = er[1];
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] l, input string tag);
    step(1'b0, 8'h0, 2'd0, 32'h0, 1'b1, a, l, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] l, input logic [31:0] d,
                    input string tag);
    step(1'b1, a, l, d, 1'b0, 8'h0, 2'd0, tag);
  endtask

  function automatic logic [7:0] pick_addr(int sel);
    case (sel)
      0: return 8'($urandom % 64);
      1: return 8'(8'hF8 + $urandom % 8);
      2: return (($urandom % 7) == 6) ? 8'h30 : 8'(16 + 4 * ($urandom % 6));
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 2; k++)
      for (int a = 0; a < 256; a++)
        mdl[k][a] = (k == 0) ? IMG0[a*8 +: 8] : IMG1[a*8 +: 8];
    last_rd[0] = '0;
    last_rd[1] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset rd_data", rd0, 32'h0);
    check("R1 reset map_upd", {31'b0, up0}, 32'h0);

    rd(8'h00, 2'd2, "R1 R2 image word");
    check("R1 literal byte order", rd0, {8'(24), 8'(17), 8'(10), 8'(3)});
    rd(8'h05, 2'd0, "R2 byte read");
    rd(8'h06, 2'd1, "R2 half read");
    rd(8'h20, 2'd3, "R2 code3 word");
    step(1'b0, 8'h0, 2'd0, 32'h0, 1'b0, 8'h0, 2'd0, "R2 hold");

    rd(8'hFC, 2'd2, "R3 word at top");
    rd(8'hFD, 2'd2, "R3 word to half");
    rd(8'hFE, 2'd2, "R3 word to half edge");
    rd(8'hFF, 2'd2, "R3 word to byte");
    check("R3 literal top byte", rd0, {24'h0, mdl[0][255]});
    rd(8'hFF, 2'd1, "R3 half to byte");

    wr(8'hFE, 2'd2, 32'hA1B2C3D4, "R4 clip write");
    rd(8'hFE, 2'd1, "R4 clip readback");
    check("R4 literal clip", rd0, 32'h0000C3D4);
    rd(8'h00, 2'd0, "R4 no wrap");
    wr(8'h3C, 2'd2, 32'h11223344, "R5 R6 mixed ro");
    rd(8'h3C, 2'd2, "R5 R6 ro readback");

    wr(8'h04, 2'd1, 32'h00000507, "R10 cmd write");
    wr(8'h06, 2'd0, 32'h000000FF, "R10 status no upd");
    wr(8'h03, 2'd1, 32'h0000AA55, "R10 overlap low");
    wr(8'h05, 2'd0, 32'h00000011, "R10 overlap high");
    rd(8'h04, 2'd1, "R10 cmd readback");

    wr(8'h10, 2'd2, 32'hFFFFFFFF, "R7 bar0 probe");
    rd(8'h10, 2'd2, "R7 bar0 readback");
    check("R7 literal io bar", rd0, 32'hFFFFFFE1);
    check("R7 literal mem bar", rd1, 32'hFFFFFF08);
    wr(8'h14, 2'd2, 32'h12345678, "R7 bar1 write");
    rd(8'h14, 2'd2, "R7 bar1 readback");
    check("R7 literal bar1", rd0, 32'h12345000);

    wr(8'h30, 2'd2, 32'hFFFFFFFF, "R8 R9 rom probe");
    rd(8'h30, 2'd2, "R8 R9 rom readback");
    check("R8 literal rom", rd0, 32'hFFFFF801);
    check("R9 R6 literal rom fallback", rd1, 32'hFFFFFFFF);
    wr(8'h30, 2'd2, 32'h0000F000, "R8 rom disable");
    rd(8'h30, 2'd2, "R8 rom disable readback");

    wr(8'h18, 2'd2, 32'hCAFEF00D, "R9 R5 R6 zero slot");
    rd(8'h18, 2'd2, "R9 zero slot readback");
    check("R9 R6 literal bridge", rd1, 32'hCAFEF00D);
    wr(8'h38, 2'd2, 32'h87654321, "R6 R5 rom ptr");
    rd(8'h38, 2'd2, "R6 rom ptr readback");
    wr(8'h3C, 2'd0, 32'h5A, "R5 irq line");

    step(1'b1, 8'h40, 2'd2, 32'hDEADBEEF, 1'b1, 8'h40, 2'd2, "R11 same cycle");
    rd(8'h40, 2'd2, "R11 after write");
    step(1'b1, 8'h10, 2'd2, 32'h0000_0000, 1'b1, 8'h10, 2'd2, "R11 R7 same slot");
    rd(8'h10, 2'd2, "R11 R7 after");

    for (int n = 0; n < 600; n++) begin
      logic we = 1'($urandom);
      logic re = 1'($urandom);
      step(we, pick_addr($urandom % 4), 2'($urandom), $urandom,
           re, pick_addr($urandom % 4), 2'($urandom), "R4 R7 R11 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule